// File: doc/BRIEF.md
# Paired-Command GPIO Bank

This block drives a small bank of general-purpose pins (up to eight) through a single 32-bit word. Software never writes a pin level or a direction bit directly. Instead, each pin owns two bit pairs, and every bit in a pair is a write-one command. The low half of the word holds a drive-low/drive-high pair for each pin. The high half holds a make-output/make-input pair for each pin. A zero in any command position does nothing, so one full-word store that carries a single command affects exactly one pin and needs no read-modify-write.

Reading the same word returns status in the same pair layout:

- The drive-low position (bit 2n) shows the pin's output latch.
- The drive-high position (bit 2n+1) shows the synchronized pin input while the pin is an input, and reads 0 while it is an output.
- The make-output position (bit 16+2n) shows the direction.
- The make-input position (bit 17+2n) shows the inverse of the direction.

With this layout, software can apply three fixed rules:

- A pin is an output when bit 16+2n is 1.
- An output pin is high when bits 16+2n and 2n are both 1.
- An input pin is high when bit 2n+1 is 1.

To toggle a pin, software reads bit 2n and then writes the drive-low command if that bit was 1, or the drive-high command if it was 0. A chip normally instantiates the bank twice, once with eight pins and once with four.

Top module: `pgpio_pair_bank`

## Requirements
- R1: After reset every pin is an input (pin_oe all 0), every output latch is 0, and with all pin inputs low the readback is 1 in bit 17+2n for each implemented pin and 0 elsewhere.
- R2: A write with bit 2n+1 set and bit 2n clear sets the output latch of pin n; pin_out[n] is 1 from the clock edge that takes the write.
- R3: A write with bit 2n set clears the output latch of pin n at the clock edge that takes the write.
- R4: A write with bit 16+2n set and bit 17+2n clear makes pin n an output (pin_oe[n]=1). A write with bit 17+2n set makes pin n an input.
- R5: A command bit written as 0 leaves its pin's latch and direction unchanged, so a write of all zeros changes nothing.
- R6: If bits 2n and 2n+1 are written together, the latch of pin n ends at 0.
- R7: If bits 16+2n and 17+2n are written together, pin n ends as an input.
- R8: The readback shows the output latch of pin n in bit 2n, the direction (1 = output) in bit 16+2n, and the inverse of the direction in bit 17+2n. Reading bit 2n and writing back bit 2n (if it was 1) or bit 2n+1 (if it was 0) inverts pin_out[n].
- R9: Bit 2n+1 of the readback is 0 while pin n is an output.
- R10: While pin n is an input, bit 2n+1 of the readback shows pin_in[n] delayed by a two-flop synchronizer. A change on the input appears after the second rising edge, not after the first.
- R11: Bits that belong to pins at or above PIN_CNT read 0, and commands in those positions have no effect on any pin.
- R12: With wr_en low, wr_data has no effect on any pin.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Command write strobe, taken at the rising edge |
| wr_data | input | 32 | Command word (pair-encoded) |
| rd_data | output | 32 | Status word (pair-encoded), reflects state after the last edge |
| pin_in | input | PIN_CNT | Raw pin inputs |
| pin_out | output | PIN_CNT | Output latches |
| pin_oe | output | PIN_CNT | Output enables, 1 = drive |

## Verification
The bench builds two instances side by side: one with PIN_CNT=8 and one with PIN_CNT=4.

The eight-pin build reaches the full 32-bit layout, including the top pin pair at bits 14/15 and 30/31. This lets whole-word writes that set and clear every pin at once confirm the priority rules across all positions.

The four-pin build is the only one where command positions belong to no pin. Writes that aim at pins 4–7 check that those bits read 0 and disturb nothing.

// File: rtl/pgpio_pkg.sv
package pgpio_pkg;

  localparam int REG_W    = 32;
  localparam int HALF_W   = REG_W / 2;
  localparam int MAX_PINS = HALF_W / 2;

  // Four command bits of one pin, pulled out of a command word.
  typedef struct packed {
    logic go_in;   // bit 17+2n
    logic go_out;  // bit 16+2n
    logic drv_hi;  // bit 2n+1
    logic drv_lo;  // bit 2n
  } pin_cmd_t;

  // Four status bits of one pin, in the same order as the commands.
  typedef struct packed {
    logic is_in;
    logic is_out;
    logic in_lvl;
    logic lat_lvl;
  } pin_stat_t;

  function automatic int lo_pos(input int n);
    return 2 * n;
  endfunction

  function automatic int hi_pos(input int n);
    return HALF_W + 2 * n;
  endfunction

  function automatic pin_cmd_t cmd_of(input logic [REG_W-1:0] w, input int n);
    pin_cmd_t c;
    c.drv_lo = w[lo_pos(n)];
    c.drv_hi = w[lo_pos(n) + 1];
    c.go_out = w[hi_pos(n)];
    c.go_in  = w[hi_pos(n) + 1];
    return c;
  endfunction

  // Latch next state: drive-low takes priority over drive-high.
  function automatic logic next_lat(input logic cur, input logic lo, input logic hi);
    if (lo)      return 1'b0;
    else if (hi) return 1'b1;
    else         return cur;
  endfunction

  // Direction next state: make-input takes priority over make-output.
  function automatic logic next_oe(input logic cur, input logic go_o, input logic go_i);
    if (go_i)      return 1'b0;
    else if (go_o) return 1'b1;
    else           return cur;
  endfunction

  function automatic pin_stat_t stat_of(input logic lat, input logic oe, input logic in_s);
    pin_stat_t s;
    s.lat_lvl = lat;
    s.in_lvl  = in_s & ~oe;
    s.is_out  = oe;
    s.is_in   = ~oe;
    return s;
  endfunction

endpackage

// File: rtl/pgpio_sync.sv
module pgpio_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_q[s] <= '0;
      end else if (s == 0) begin
        stage_q[s] <= d;
      end else begin
        stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/pgpio_pin_cell.sv
module pgpio_pin_cell
  import pgpio_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr_en,
  input  pin_cmd_t  cmd,
  input  logic      in_sync,
  output logic      lat_q,
  output logic      oe_q,
  output pin_stat_t stat
);
  logic lat_d;
  logic oe_d;

  always_comb begin
    lat_d = lat_q;
    oe_d  = oe_q;
    if (wr_en) begin
      lat_d = next_lat(lat_q, cmd.drv_lo, cmd.drv_hi);
      oe_d  = next_oe(oe_q, cmd.go_out, cmd.go_in);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      lat_q <= lat_d;
      oe_q  <= oe_d;
    end
  end

  assign stat = stat_of(lat_q, oe_q, in_sync);
endmodule

// File: rtl/pgpio_rd_pack.sv
module pgpio_rd_pack
  import pgpio_pkg::*;
#(
  parameter int PIN_CNT = 8
) (
  input  pin_stat_t              stat [PIN_CNT],
  output logic [REG_W-1:0]       word
);
  for (genvar n = 0; n < MAX_PINS; n++) begin : g_slot
    if (n < PIN_CNT) begin : g_used
      assign word[2*n]            = stat[n].lat_lvl;
      assign word[2*n+1]          = stat[n].in_lvl;
      assign word[HALF_W+2*n]     = stat[n].is_out;
      assign word[HALF_W+2*n+1]   = stat[n].is_in;
    end else begin : g_empty
      assign word[2*n]            = 1'b0;
      assign word[2*n+1]          = 1'b0;
      assign word[HALF_W+2*n]     = 1'b0;
      assign word[HALF_W+2*n+1]   = 1'b0;
    end
  end
endmodule

// File: rtl/pgpio_pair_bank.sv
module pgpio_pair_bank
  import pgpio_pkg::*;
#(
  parameter int PIN_CNT     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [31:0]        wr_data,
  output logic [31:0]        rd_data,
  input  logic [PIN_CNT-1:0] pin_in,
  output logic [PIN_CNT-1:0] pin_out,
  output logic [PIN_CNT-1:0] pin_oe
);
  logic [PIN_CNT-1:0] in_sync;
  pin_cmd_t           cmd  [PIN_CNT];
  pin_stat_t          stat [PIN_CNT];

  // Named per-pin command events, visible to the checker.
  logic [PIN_CNT-1:0] evt_lo;
  logic [PIN_CNT-1:0] evt_hi;
  logic [PIN_CNT-1:0] evt_out;
  logic [PIN_CNT-1:0] evt_in;

  pgpio_sync #(.WIDTH(PIN_CNT), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pin_in),
    .q     (in_sync)
  );

  for (genvar n = 0; n < PIN_CNT; n++) begin : g_pin
    assign cmd[n]     = cmd_of(wr_data, n);
    assign evt_lo[n]  = wr_en & cmd[n].drv_lo;
    assign evt_hi[n]  = wr_en & cmd[n].drv_hi;
    assign evt_out[n] = wr_en & cmd[n].go_out;
    assign evt_in[n]  = wr_en & cmd[n].go_in;

    pgpio_pin_cell u_cell (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .cmd     (cmd[n]),
      .in_sync (in_sync[n]),
      .lat_q   (pin_out[n]),
      .oe_q    (pin_oe[n]),
      .stat    (stat[n])
    );
  end

  pgpio_rd_pack #(.PIN_CNT(PIN_CNT)) u_pack (
    .stat (stat),
    .word (rd_data)
  );
endmodule

// File: rtl/pgpio_pair_bank_chk.sv
module pgpio_pair_bank_chk #(
  parameter int PIN_CNT = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_en,
  input logic [31:0]        wr_data,
  input logic [31:0]        rd_data,
  input logic [PIN_CNT-1:0] pin_in,
  input logic [PIN_CNT-1:0] pin_out,
  input logic [PIN_CNT-1:0] pin_oe
);
  localparam logic [15:0] LO_USED = 16'((32'd1 << (2*PIN_CNT)) - 1);
  localparam logic [31:0] USED    = {LO_USED, LO_USED};

  logic [1:0] up_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            up_cnt <= '0;
    else if (up_cnt != 2'd3) up_cnt <= up_cnt + 2'd1;
  end

  assert_unused_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data & ~USED) == 32'h0);

  for (genvar n = 0; n < PIN_CNT; n++) begin : g_p
    assert_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && wr_data[2*n+1] && !wr_data[2*n] |=> pin_out[n]);
    assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && wr_data[2*n] |=> !pin_out[n]);   // also covers R6
    assert_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && wr_data[16+2*n] && !wr_data[17+2*n] |=> pin_oe[n]);
    assert_disable_R7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && wr_data[17+2*n] |=> !pin_oe[n]);
    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && (wr_data[2*n] || wr_data[2*n+1])) |=> $stable(pin_out[n]));
    assert_hold_dir_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(pin_oe[n]));
    assert_readback_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[2*n] == pin_out[n] && rd_data[16+2*n] == pin_oe[n]
      && rd_data[17+2*n] == !pin_oe[n]);
    assert_out_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
      pin_oe[n] |-> !rd_data[2*n+1]);
    assert_sync_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (up_cnt == 2'd3) && !pin_oe[n] |-> rd_data[2*n+1] == $past(pin_in[n], 2));
  end
endmodule

bind pgpio_pair_bank pgpio_pair_bank_chk #(.PIN_CNT(PIN_CNT)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_en   (wr_en),
  .wr_data (wr_data),
  .rd_data (rd_data),
  .pin_in  (pin_in),
  .pin_out (pin_out),
  .pin_oe  (pin_oe)
);

// File: tb/tb_pgpio_pair_bank.sv
module tb_pgpio_pair_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [7:0]  pin_in = '0;
  logic [7:0]  pin_out;
  logic [7:0]  pin_oe;

  logic        wr_en_s = 1'b0;
  logic [31:0] wr_data_s = '0;
  logic [31:0] rd_data_s;
  logic [3:0]  pin_in_s = '0;
  logic [3:0]  pin_out_s;
  logic [3:0]  pin_oe_s;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pgpio_pair_bank #(.PIN_CNT(8)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe));

  pgpio_pair_bank #(.PIN_CNT(4)) dut_small (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en_s), .wr_data(wr_data_s),
    .rd_data(rd_data_s), .pin_in(pin_in_s), .pin_out(pin_out_s), .pin_oe(pin_oe_s));

  typedef struct packed {
    logic [31:0] w;
    logic [7:0]  e_out;
    logic [7:0]  e_oe;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{32'h0000_0002, 8'h01, 8'h00, 8'd2},
    '{32'h0001_0000, 8'h01, 8'h01, 8'd4},
    '{32'h0000_8000, 8'h81, 8'h01, 8'd2},
    '{32'h0000_0000, 8'h81, 8'h01, 8'd5},
    '{32'h0000_0001, 8'h80, 8'h01, 8'd3},
    '{32'h0000_0008, 8'h82, 8'h01, 8'd2},
    '{32'h0000_000C, 8'h80, 8'h01, 8'd6},
    '{32'h5555_0000, 8'h80, 8'hFF, 8'd4},
    '{32'h000C_0000, 8'h80, 8'hFD, 8'd7},
    '{32'h0002_0000, 8'h80, 8'hFC, 8'd4},
    '{32'hAAAA_AAAA, 8'hFF, 8'h00, 8'd4},
    '{32'h5555_5555, 8'h00, 8'hFF, 8'd3}
  };

  // Expected status word from the R8/R9/R10 rules.
  function automatic logic [31:0] exp_rd(input logic [7:0] o, input logic [7:0] e,
                                         input logic [7:0] i, input int np);
    logic [31:0] r = '0;
    for (int k = 0; k < np; k++) begin
      r[2*k]    = o[k];
      r[2*k+1]  = i[k] && !e[k];
      r[16+2*k] = e[k];
      r[17+2*k] = !e[k];
    end
    return r;
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr8(input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic wr4(input logic [31:0] d);
    @(negedge clk);
    wr_en_s = 1'b1; wr_data_s = d;
    @(negedge clk);
    wr_en_s = 1'b0; wr_data_s = '0;
  endtask

  initial begin
    for (int c = 0; c < 200000; c++) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] o_before;
    logic [7:0] e_before;
    logic [31:0] r;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 / R11: reset state, unused slots read 0
    check("R1", "pin_out", 32'(pin_out), 32'h0);
    check("R1", "pin_oe", 32'(pin_oe), 32'h0);
    check("R1", "rd_data", rd_data, 32'hAAAA_0000);
    check("R11", "small rd_data", rd_data_s, 32'h00AA_0000);

    // Table walk (R2..R7), readback per R8
    for (int v = 0; v < NV; v++) begin
      wr8(VECS[v].w);
      check($sformatf("R%0d", VECS[v].req), $sformatf("vec%0d pin_out", v),
            32'(pin_out), 32'(VECS[v].e_out));
      check($sformatf("R%0d", VECS[v].req), $sformatf("vec%0d pin_oe", v),
            32'(pin_oe), 32'(VECS[v].e_oe));
      check("R8", $sformatf("vec%0d rd_data", v), rd_data,
            exp_rd(VECS[v].e_out, VECS[v].e_oe, 8'h00, 8));
    end

    // R12: strobe low, full command word present
    o_before = pin_out; e_before = pin_oe;
    @(negedge clk);
    wr_data = 32'hAAAA_AAAA;
    repeat (2) @(negedge clk);
    wr_data = '0;
    check("R12", "pin_out", 32'(pin_out), 32'(o_before));
    check("R12", "pin_oe", 32'(pin_oe), 32'(e_before));

    // R10: two-flop input delay
    wr8(32'hAAAA_0000);
    check("R4", "all inputs", 32'(pin_oe), 32'h0);
    pin_in = 8'h5A;
    @(negedge clk);
    check("R10", "after one edge", rd_data, exp_rd(8'h00, 8'h00, 8'h00, 8));
    @(negedge clk);
    check("R10", "after two edges", rd_data, exp_rd(8'h00, 8'h00, 8'h5A, 8));

    // R9: output pin masks its input level
    check("R9", "pin1 input high", 32'(rd_data[3]), 32'h1);
    wr8(32'h0004_0000);
    check("R9", "pin1 output bit3", 32'(rd_data[3]), 32'h0);
    check("R9", "rd_data", rd_data, exp_rd(8'h00, 8'h02, 8'h5A, 8));

    // R8: toggle by read-then-command on pin 3
    wr8(32'h0040_0000);
    for (int t = 0; t < 2; t++) begin
      logic was;
      was = pin_out[3];
      r = rd_data;
      wr8(r[6] ? 32'h0000_0040 : 32'h0000_0080);
      check("R8", $sformatf("toggle %0d pin_out[3]", t), 32'(pin_out[3]), 32'(!was));
      check("R8", $sformatf("toggle %0d output-high view", t),
            32'(rd_data[22] && rd_data[6]), 32'(!was));
    end

    // R11: commands aimed at absent pins of the 4-pin bank
    wr4(32'h5500_AA00);
    check("R11", "small pin_out", 32'(pin_out_s), 32'h0);
    check("R11", "small pin_oe", 32'(pin_oe_s), 32'h0);
    check("R11", "small rd_data", rd_data_s, 32'h00AA_0000);
    wr4(32'h0055_00AA);
    check("R2", "small set all", 32'(pin_out_s), 32'hF);
    check("R4", "small enable all", rd_data_s, 32'h0055_0055);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule